// File: doc/BRIEF.md
# Signed Multiply Unit with Overflow Flags

This unit performs signed integer multiplication for an execution pipeline. It handles operand sizes of 8, 16, 32 and 64 bits and three operation forms. The widening form multiplies an accumulator operand by a source and returns the full double-width product. The truncating form multiplies a destination operand by a source and keeps only the low operand-size bits. The immediate form multiplies a source by a sign-extended immediate and keeps only the low operand-size bits. Every form also computes the double-width product internally. It raises both carry and overflow when the truncated low part, sign-extended, does not equal the full product.

Operands arrive on 64-bit buses, and only their low operand-size bits are used. Results appear one clock after a valid strobe, together with a one-cycle done pulse. The outputs then hold their values until the next strobe. Instruction decode, register file, memory and exceptions all belong to the surrounding core.

Top module: `imul_unit`

## Requirements
- R1: With form_i=0 (widening) and size_i of 1, 2 or 3 (16, 32, 64 bits), res_lo_o holds the low n bits of the signed product opa*opb, res_hi_o holds the high n bits, and hi_we_o is 1.
- R2: With form_i=0 and size_i=0 (8 bits), res_lo_o[15:0] holds the whole 16-bit signed product, while res_hi_o is 0 and hi_we_o is 0.
- R3: With form_i=1 (truncating), res_lo_o holds the low n bits of opa*opb, while res_hi_o is 0 and hi_we_o is 0. Because these low bits are the same for signed and unsigned operands, the result is also correct for unsigned inputs.
- R4: With form_i=2 (immediate), res_lo_o holds the low n bits of opb times the immediate, and hi_we_o is 0. The immediate is the low 8, 16 or 32 bits of imm_i for imm_sz_i equal to 0, 1 or 2. It is sign-extended to the operand size, so a 32-bit immediate used at 64 bits becomes negative when bit 31 is set.
- R5: cf_o and of_o are both 1 when sign-extending the low n bits of the full 2n-bit product does not reproduce that product. Otherwise both are 0. The two flags always carry the same value.
- R6: sf_o, zf_o, af_o and pf_o carry no defined value and are always driven to 0.
- R7: All results update on the rising edge that samples valid_i=1, and done_o is 1 for exactly that following cycle. When valid_i=0, done_o is 0 on the next cycle and the result outputs keep their values.
- R8: Operand bits above the operand size n (size_i 0..3 gives n = 8, 16, 32, 64) have no effect. Output bits above n are 0, except that in the R2 case res_lo_o[15:8] carries the upper product byte.
- R9: While rst_ni is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| form_i | input | 2 | 0 widening, 1 truncating, 2 immediate |
| size_i | input | 2 | Operand size: 0=8, 1=16, 2=32, 3=64 bits |
| imm_sz_i | input | 2 | Immediate width: 0=8, 1=16, 2=32 bits |
| opa_i | input | 64 | Accumulator or destination operand |
| opb_i | input | 64 | Source operand |
| imm_i | input | 32 | Immediate value |
| res_lo_o | output | 64 | Low result word |
| res_hi_o | output | 64 | High result word |
| hi_we_o | output | 1 | High result word is to be written |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| sf_o | output | 1 | Sign flag, driven 0 |
| zf_o | output | 1 | Zero flag, driven 0 |
| af_o | output | 1 | Auxiliary carry flag, driven 0 |
| pf_o | output | 1 | Parity flag, driven 0 |
| done_o | output | 1 | Result valid pulse |

## Verification
The hardest condition to reach is the overflow boundary. This is a product that only just fits in n signed bits, or only just misses, and uniformly random 64-bit operands almost never land there. The stimulus reaches it in two ways. First, it biases part of the random operands toward small sign-extended values whose products cluster around each size limit. Second, it adds directed pairs: the most negative value times -1, the most negative value times itself, and factor pairs placed on either side of the limit. Random high-order garbage on the operand buses shows whether the bits above the operand size leak into the product.

// File: rtl/imul_pkg.sv
package imul_pkg;
  localparam int W     = 64;
  localparam int NSZ   = 4;
  localparam int BASE  = 8;
  localparam int IMM_W = 32;

  typedef enum logic [1:0] {F_ONE = 2'd0, F_TWO = 2'd1, F_THREE = 2'd2, F_RSV = 2'd3} form_e;
  typedef enum logic [1:0] {SZ_8 = 2'd0, SZ_16 = 2'd1, SZ_32 = 2'd2, SZ_64 = 2'd3} size_e;
  typedef enum logic [1:0] {IW_8 = 2'd0, IW_16 = 2'd1, IW_32 = 2'd2, IW_RSV = 2'd3} immw_e;

  function automatic logic [W-1:0] sext_sz(input logic [W-1:0] v, input logic [1:0] sz);
    case (sz)
      SZ_8:    return {{(W-8){v[7]}}, v[7:0]};
      SZ_16:   return {{(W-16){v[15]}}, v[15:0]};
      SZ_32:   return {{(W-32){v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

  function automatic logic [W-1:0] sext_imm(input logic [IMM_W-1:0] v, input logic [1:0] iw);
    case (iw)
      IW_8:    return {{(W-8){v[7]}}, v[7:0]};
      IW_16:   return {{(W-16){v[15]}}, v[15:0]};
      default: return {{(W-IMM_W){v[IMM_W-1]}}, v};
    endcase
  endfunction

  function automatic logic [W-1:0] size_mask(input logic [1:0] sz);
    return {W{1'b1}} >> (W - (BASE << sz));
  endfunction
endpackage

// File: rtl/imul_prep.sv
module imul_prep
  import imul_pkg::*;
(
  input  logic [1:0]       form_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       imm_sz_i,
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [W-1:0]     mul_a_o,
  output logic [W-1:0]     mul_b_o
);
  logic is_three;
  assign is_three = (form_i == F_THREE);

  // immediate form: source is opb, second factor is the immediate
  always_comb begin
    mul_a_o = sext_sz(is_three ? opb_i : opa_i, size_i);
    mul_b_o = sext_sz(is_three ? sext_imm(imm_i, imm_sz_i) : opb_i, size_i);
  end
endmodule

// File: rtl/imul_mult.sv
module imul_mult #(
  parameter int W = 64
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  logic signed [2*W-1:0] a_x, b_x;
  assign a_x = {{W{a_i[W-1]}}, a_i};
  assign b_x = {{W{b_i[W-1]}}, b_i};
  assign p_o = a_x * b_x;
endmodule

// File: rtl/imul_pack.sv
module imul_pack
  import imul_pkg::*;
(
  input  logic [2*W-1:0] p_i,
  input  logic [1:0]     form_i,
  input  logic [1:0]     size_i,
  output logic [W-1:0]   lo_o,
  output logic [W-1:0]   hi_o,
  output logic           hi_we_o,
  output logic           ovf_o
);
  logic [W-1:0] lo_w  [NSZ];
  logic [W-1:0] hi_w  [NSZ];
  logic         ovf_w [NSZ];

  for (genvar k = 0; k < NSZ; k++) begin : g_sz
    localparam int N = BASE << k;
    localparam logic [W-1:0] MSK = {W{1'b1}} >> (W - N);
    logic [2*W-1:0] shr, sxt;
    assign shr      = p_i >> N;
    assign sxt      = {{(2*W-N){p_i[N-1]}}, p_i[N-1:0]};
    assign lo_w[k]  = p_i[W-1:0] & MSK;
    assign hi_w[k]  = shr[W-1:0] & MSK;
    assign ovf_w[k] = (sxt != p_i);
  end

  logic wide, one8;
  assign one8 = (form_i == F_ONE) && (size_i == SZ_8);
  assign wide = (form_i == F_ONE) && (size_i != SZ_8);

  always_comb begin
    lo_o    = one8 ? lo_w[SZ_16] : lo_w[size_i];
    hi_o    = wide ? hi_w[size_i] : '0;
    hi_we_o = wide;
    ovf_o   = ovf_w[size_i];
  end
endmodule

// File: rtl/imul_unit.sv
module imul_unit
  import imul_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       form_i,
  input  logic [1:0]       size_i,
  input  logic [1:0]       imm_sz_i,
  input  logic [W-1:0]     opa_i,
  input  logic [W-1:0]     opb_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [W-1:0]     res_lo_o,
  output logic [W-1:0]     res_hi_o,
  output logic             hi_we_o,
  output logic             cf_o,
  output logic             of_o,
  output logic             sf_o,
  output logic             zf_o,
  output logic             af_o,
  output logic             pf_o,
  output logic             done_o
);
  logic [W-1:0]   mul_a, mul_b, lo_d, hi_d;
  logic [2*W-1:0] prod;
  logic           hi_we_d, ovf_d;

  imul_prep u_prep (
    .form_i(form_i), .size_i(size_i), .imm_sz_i(imm_sz_i),
    .opa_i(opa_i), .opb_i(opb_i), .imm_i(imm_i),
    .mul_a_o(mul_a), .mul_b_o(mul_b)
  );

  imul_mult #(.W(W)) u_mult (.a_i(mul_a), .b_i(mul_b), .p_o(prod));

  imul_pack u_pack (
    .p_i(prod), .form_i(form_i), .size_i(size_i),
    .lo_o(lo_d), .hi_o(hi_d), .hi_we_o(hi_we_d), .ovf_o(ovf_d)
  );

  logic ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_lo_o <= '0;
      res_hi_o <= '0;
      hi_we_o  <= 1'b0;
      ovf_q    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        res_lo_o <= lo_d;
        res_hi_o <= hi_d;
        hi_we_o  <= hi_we_d;
        ovf_q    <= ovf_d;
      end
    end
  end

  assign cf_o = ovf_q;
  assign of_o = ovf_q;
  // undefined flags
  assign sf_o = 1'b0;
  assign zf_o = 1'b0;
  assign af_o = 1'b0;
  assign pf_o = 1'b0;

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!done_o && $stable(res_lo_o) && $stable(res_hi_o) && $stable(cf_o)));
  p_hi_we_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (hi_we_o == ($past(form_i) == F_ONE && $past(size_i) != SZ_8)));
  p_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((res_hi_o & ~size_mask($past(size_i))) == '0));
  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hi_we_o && !cf_o) |->
      (res_hi_o == (res_lo_o[(BASE << $past(size_i)) - 1] ? size_mask($past(size_i)) : '0)));
endmodule

// File: tb/sim_imul_unit.sv
module sim_imul_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [1:0]   form = '0, size = '0, iw = '0;
  logic [63:0]  opa = '0, opb = '0;
  logic [31:0]  imm = '0;
  logic [63:0]  res_lo, res_hi;
  logic         hi_we, cf, of_f, sf, zf, af, pf, done;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  imul_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .form_i(form), .size_i(size),
    .imm_sz_i(iw), .opa_i(opa), .opb_i(opb), .imm_i(imm),
    .res_lo_o(res_lo), .res_hi_o(res_hi), .hi_we_o(hi_we), .cf_o(cf), .of_o(of_f),
    .sf_o(sf), .zf_o(zf), .af_o(af), .pf_o(pf), .done_o(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] sx(input logic [63:0] v, input int n);
    logic signed [127:0] t;
    t = {v, 64'b0};
    t = t <<< (64 - n);
    t = t >>> (128 - n);
    return t;
  endfunction

  function automatic logic [63:0] msk(input int n);
    return (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  task automatic run(input logic [1:0] f, input logic [1:0] s, input logic [1:0] w,
                     input logic [63:0] a, input logic [63:0] b, input logic [31:0] im);
    int n;
    logic signed [127:0] ea, eb, p;
    logic [127:0] sh;
    logic [63:0] e_lo, e_hi, old_lo;
    logic e_we, e_ovf;
    string tag;
    n  = 8 << s;
    ea = sx((f == 2) ? b : a, n);
    eb = (f == 2) ? sx(sx({32'b0, im}, 8 << w)[63:0], n) : sx(b, n);
    p  = ea * eb;
    sh = p >> n;
    e_ovf = (sx(p[63:0], n) != p);
    e_we  = (f == 0) && (n > 8);
    e_lo  = (f == 0 && n == 8) ? {48'b0, p[15:0]} : (p[63:0] & msk(n));
    e_hi  = e_we ? (sh[63:0] & msk(n)) : '0;
    tag = (f == 0) ? ((n == 8) ? "R2" : "R1") : ((f == 1) ? "R3" : "R4");
    @(negedge clk);
    form = f; size = s; iw = w; opa = a; opb = b; imm = im; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    chk({tag, " lo"}, res_lo, e_lo);
    chk({tag, " R8 hi"}, res_hi, e_hi);
    chk({tag, " hi_we"}, {63'b0, hi_we}, {63'b0, e_we});
    chk("R5 cf", {63'b0, cf}, {63'b0, e_ovf});
    chk("R5 of", {63'b0, of_f}, {63'b0, e_ovf});
    chk("R6 undef", {60'b0, sf, zf, af, pf}, '0);
    chk("R7 done", {63'b0, done}, 64'd1);
    old_lo = res_lo;
    opa = ~opa; opb = ~opb;
    @(negedge clk);
    chk("R7 hold done", {63'b0, done}, '0);
    chk("R7 hold lo", res_lo, old_lo);
  endtask

  function automatic logic [63:0] rnd_op();
    logic [63:0] v;
    v = {$urandom, $urandom};
    if ($urandom_range(0, 2) == 0) v = {v[63:8], 8'(v[3:0]) - 8'd8} ^ 64'h0;
    if ($urandom_range(0, 3) == 0) v[7:0] = 8'($signed(v[5:0]));
    return v;
  endfunction

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R9 reset lo", res_lo, '0);
    chk("R9 reset hi", res_hi, '0);
    chk("R9 reset flags", {57'b0, hi_we, cf, of_f, sf, zf, af, done}, '0);
    rst_n = 1'b1;

    for (int s = 0; s < 4; s++) begin
      int n = 8 << s;
      logic [63:0] mn = 64'hDEAD_BEEF_0000_0000 | (64'd1 << (n - 1));
      for (int f = 0; f < 3; f++) begin
        run(2'(f), 2'(s), 2'd0, mn, '1, 32'hFFFF_FFFF);
        run(2'(f), 2'(s), 2'd0, mn, mn, 32'h0000_0080);
      end
    end
    run(2'd1, 2'd0, 2'd0, 64'hFF, 64'h0, 0);                // zero
    run(2'd1, 2'd0, 2'd0, 64'hF8, 64'h10, 0);               // -8*16 fits
    run(2'd1, 2'd0, 2'd0, 64'h08, 64'h10, 0);               // 8*16 overflows
    run(2'd1, 2'd1, 2'd0, 64'd181, 64'd181, 0);             // fits 16
    run(2'd1, 2'd1, 2'd0, 64'd182, 64'd181, 0);             // overflows 16
    run(2'd1, 2'd0, 2'd0, 64'd200, 64'd3, 0);               // unsigned low R3
    run(2'd2, 2'd3, 2'd2, 64'd5, 64'd3, 32'h8000_0000);     // imm32 negative R4
    run(2'd2, 2'd2, 2'd0, 64'd0, 64'd1000, 32'h0000_00FE);  // imm8 -2 R4
    run(2'd2, 2'd1, 2'd1, 64'd0, 64'd3, 32'h1234_8000);     // imm16 R4
    run(2'd0, 2'd3, 2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 0);

    for (int i = 0; i < 3000; i++)
      run(2'($urandom_range(0, 2)), 2'($urandom_range(0, 3)), 2'($urandom_range(0, 2)),
          rnd_op(), rnd_op(), $urandom);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule